// File: doc/BRIEF.md
# Packed Byte Dot-Product Execution Unit

This unit is one execution pipe of a SIMT core. It watches a stream of 32-bit instruction words. When an issued word carries the custom dot-product encoding, every active thread lane treats its two 32-bit source operands as four signed 8-bit elements each. The lane multiplies matching elements and adds the four products into one signed 32-bit result.

Results leave the unit a fixed two clock cycles after issue. They come with a per-lane write mask, the destination register index taken from the instruction, and an opaque tag supplied by the issuing logic. Lanes whose thread bit is clear produce no write. An issued word with any other encoding is flagged as illegal on the same schedule and produces no result.

The unit takes a new instruction on every cycle. Because the latency is fixed, results always come out in the order they were issued.

Top module: `dp8_unit`

## Requirements
- R1: An issued word is accepted only when bits [6:0] equal 7'h0B, bits [14:12] equal 3'd0 and bits [31:25] equal 7'd3.
- R2: In lane i, operand element e sits in bits [32i+8e+7 : 32i+8e] of the packed lane bus, so element 0 is the least significant byte. Each element is read as a two's-complement 8-bit value.
- R3: A lane result is the signed 32-bit sum of the four element products from in_rs1 and in_rs2. It always lies between -65024 and 65536.
- R4: out_valid is high in exactly the cycle that follows the second rising edge after an accepted issue.
- R5: With out_valid high, out_wmask equals the issued thread mask. A lane whose mask bit is clear returns a result of zero. With out_valid low, out_wmask is zero.
- R6: With out_valid high, out_rd equals bits [11:7] of the accepted word, and out_tag equals the in_tag given with it.
- R7: An issued word that fails the R1 match raises out_illegal two cycles later and never raises out_valid. out_valid and out_illegal are never high together.
- R8: Issues on consecutive cycles each produce their own result, two cycles later, in issue order.
- R9: After a synchronous active-high reset, out_valid, out_illegal and out_wmask are zero.
- R10: A cycle with in_valid low produces neither out_valid nor out_illegal, whatever the instruction bus holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe |
| in_instr | input | 32 | Instruction word |
| in_rs1 | input | LANES*32 | Packed A operand, one 32-bit word per lane |
| in_rs2 | input | LANES*32 | Packed B operand, one 32-bit word per lane |
| in_tmask | input | LANES | Thread-active mask |
| in_tag | input | TAG_W | Issue tag carried to the output |
| out_valid | output | 1 | Result valid |
| out_result | output | LANES*32 | Per-lane signed 32-bit results |
| out_wmask | output | LANES | Per-lane register write enable |
| out_rd | output | 5 | Destination register index |
| out_tag | output | TAG_W | Tag of the returning instruction |
| out_illegal | output | 1 | Unrecognised encoding was issued |

## Verification
The bench builds the unit with its defaults: four lanes and a 6-bit tag. Four lanes are enough to place different byte patterns side by side in one issue, for example a single non-zero element in a different byte position in each lane. They also allow sparse and empty thread masks, so masking is checked per lane and not only as a whole-word effect. The directed cases reach both extremes of the sum, (-128)*(-128) and (-128)*127 in all four elements, along with a mismatch in each decoded field. A seeded random stream, issuing on almost every cycle, then covers back-to-back ordering.

// File: rtl/dp8_pkg.sv
package dp8_pkg;

    // Encoding of the accepted instruction
    localparam logic [6:0] OPC_CUSTOM0 = 7'h0B;
    localparam logic [2:0] FN3_DOT     = 3'd0;
    localparam logic [6:0] FN7_DOT     = 7'd3;

    localparam int ELEMS  = 4;
    localparam int ELEM_W = 8;
    localparam int WORD_W = ELEMS * ELEM_W;
    localparam int PROD_W = 2 * ELEM_W;
    localparam int PAIR_W = PROD_W + 1;
    localparam int TOT_W  = PROD_W + 2;

    typedef logic [4:0] regidx_t;

    typedef struct packed {
        logic    valid;
        logic    illegal;
        regidx_t rd;
    } ctl_t;

    function automatic logic is_dot8(input logic [31:0] w);
        return (w[6:0] == OPC_CUSTOM0) && (w[14:12] == FN3_DOT) && (w[31:25] == FN7_DOT);
    endfunction

    function automatic logic signed [PROD_W-1:0] smul8(input logic [ELEM_W-1:0] x,
                                                       input logic [ELEM_W-1:0] y);
        logic signed [PROD_W-1:0] xs;
        logic signed [PROD_W-1:0] ys;
        xs = {{ELEM_W{x[ELEM_W-1]}}, x};
        ys = {{ELEM_W{y[ELEM_W-1]}}, y};
        return xs * ys;
    endfunction

endpackage

// File: rtl/dp8_decode.sv
module dp8_decode
    import dp8_pkg::*;
(
    input  logic [31:0] instr,
    output logic        hit,
    output regidx_t     rd
);
    assign hit = is_dot8(instr);
    assign rd  = instr[11:7];
endmodule

// File: rtl/dp8_lane.sv
module dp8_lane
    import dp8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [31:0]       res
);
    logic signed [PROD_W-1:0] prod [ELEMS];

    for (genvar e = 0; e < ELEMS; e++) begin : g_mul
        assign prod[e] = smul8(a[e*ELEM_W +: ELEM_W], b[e*ELEM_W +: ELEM_W]);
    end

    // Stage 1: two pair sums, cleared when the lane is idle or masked
    logic signed [PAIR_W-1:0] lo_q, hi_q;
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= {prod[0][PROD_W-1], prod[0]} + {prod[1][PROD_W-1], prod[1]};
            hi_q <= {prod[2][PROD_W-1], prod[2]} + {prod[3][PROD_W-1], prod[3]};
        end
    end

    // Stage 2: final add and sign extension to 32 bits
    logic signed [TOT_W-1:0] tot;
    assign tot = {lo_q[PAIR_W-1], lo_q} + {hi_q[PAIR_W-1], hi_q};

    always_ff @(posedge clk) begin
        if (rst) res <= '0;
        else     res <= {{(32-TOT_W){tot[TOT_W-1]}}, tot};
    end
endmodule

// File: rtl/dp8_ctl.sv
module dp8_ctl
    import dp8_pkg::*;
#(
    parameter int LANES = 4,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_hit,
    input  logic [LANES-1:0] in_mask,
    input  regidx_t          in_rd,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [LANES-1:0] out_mask,
    output regidx_t          out_rd,
    output logic [TAG_W-1:0] out_tag
);
    ctl_t             c1, c2;
    logic [LANES-1:0] m1, m2;
    logic [TAG_W-1:0] t1, t2;
    logic             take;

    assign take = in_valid && in_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            c1 <= '0; c2 <= '0;
            m1 <= '0; m2 <= '0;
            t1 <= '0; t2 <= '0;
        end else begin
            c1.valid   <= take;
            c1.illegal <= in_valid && !in_hit;
            c1.rd      <= in_rd;
            m1         <= take ? in_mask : '0;
            t1         <= in_tag;
            c2         <= c1;
            m2         <= m1;
            t2         <= t1;
        end
    end

    assign out_valid   = c2.valid;
    assign out_illegal = c2.illegal;
    assign out_rd      = c2.rd;
    assign out_mask    = m2;
    assign out_tag     = t2;
endmodule

// File: rtl/dp8_unit.sv
module dp8_unit
    import dp8_pkg::*;
#(
    parameter int LANES = 4,
    parameter int TAG_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [31:0]             in_instr,
    input  logic [LANES*WORD_W-1:0] in_rs1,
    input  logic [LANES*WORD_W-1:0] in_rs2,
    input  logic [LANES-1:0]        in_tmask,
    input  logic [TAG_W-1:0]        in_tag,
    output logic                    out_valid,
    output logic [LANES*32-1:0]     out_result,
    output logic [LANES-1:0]        out_wmask,
    output logic [4:0]              out_rd,
    output logic [TAG_W-1:0]        out_tag,
    output logic                    out_illegal
);
    logic    hit;
    regidx_t rd_f;

    dp8_decode u_dec (
        .instr (in_instr),
        .hit   (hit),
        .rd    (rd_f)
    );

    dp8_ctl #(.LANES(LANES), .TAG_W(TAG_W)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_hit      (hit),
        .in_mask     (in_tmask),
        .in_rd       (rd_f),
        .in_tag      (in_tag),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_mask    (out_wmask),
        .out_rd      (out_rd),
        .out_tag     (out_tag)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dp8_lane u_lane (
            .clk (clk),
            .rst (rst),
            .en  (in_valid && hit && in_tmask[g]),
            .a   (in_rs1[g*WORD_W +: WORD_W]),
            .b   (in_rs2[g*WORD_W +: WORD_W]),
            .res (out_result[g*32 +: 32])
        );
    end
endmodule

// File: rtl/dp8_unit_chk.sv
module dp8_unit_chk #(
    parameter int LANES = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [31:0]         in_instr,
    input logic [LANES-1:0]    in_tmask,
    input logic                out_valid,
    input logic                out_illegal,
    input logic [LANES*32-1:0] out_result,
    input logic [LANES-1:0]    out_wmask,
    input logic [4:0]          out_rd
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    logic enc_ok, fire_in, bad_in;
    assign enc_ok  = (in_instr[6:0] == 7'h0B) && (in_instr[14:12] == 3'd0)
                  && (in_instr[31:25] == 7'd3);
    assign fire_in = in_valid && enc_ok;
    assign bad_in  = in_valid && !enc_ok;

    logic range_bad, masked_bad;
    always_comb begin
        range_bad  = 1'b0;
        masked_bad = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if ($signed(out_result[i*32 +: 32]) > 65536 ||
                $signed(out_result[i*32 +: 32]) < -65024) range_bad = 1'b1;
            if (!out_wmask[i] && out_result[i*32 +: 32] != 32'd0) masked_bad = 1'b1;
        end
    end

    // R1 R4: accepted issues come back exactly two cycles later
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (out_valid == $past(fire_in, 2)));

    p_illegal_r7: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (out_illegal == $past(bad_in, 2)));

    p_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_illegal));

    p_wmask_r5: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (out_wmask == ($past(fire_in, 2) ? $past(in_tmask, 2) : '0)));

    p_masked_zero_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !masked_bad);

    p_rd_r6: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && out_valid) |-> (out_rd == $past(in_instr[11:7], 2)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !range_bad);
endmodule

bind dp8_unit dp8_unit_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_instr    (in_instr),
    .in_tmask    (in_tmask),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_result  (out_result),
    .out_wmask   (out_wmask),
    .out_rd      (out_rd)
);

// File: tb/dp8_unit_tb_top.sv
`timescale 1ns/1ps
module dp8_unit_tb_top;
    localparam int LANES = 4;
    localparam int TAG_W = 6;
    localparam int NC    = 300;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [31:0]         in_instr = '0;
    logic [LANES*32-1:0] in_rs1 = '0;
    logic [LANES*32-1:0] in_rs2 = '0;
    logic [LANES-1:0]    in_tmask = '0;
    logic [TAG_W-1:0]    in_tag = '0;
    logic                out_valid;
    logic [LANES*32-1:0] out_result;
    logic [LANES-1:0]    out_wmask;
    logic [4:0]          out_rd;
    logic [TAG_W-1:0]    out_tag;
    logic                out_illegal;

    always #4 clk = ~clk;

    dp8_unit #(.LANES(LANES), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_rs1(in_rs1), .in_rs2(in_rs2), .in_tmask(in_tmask), .in_tag(in_tag),
        .out_valid(out_valid), .out_result(out_result), .out_wmask(out_wmask),
        .out_rd(out_rd), .out_tag(out_tag), .out_illegal(out_illegal)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic                s_valid [NC];
    logic [31:0]         s_instr [NC];
    logic [LANES*32-1:0] s_a     [NC];
    logic [LANES*32-1:0] s_b     [NC];
    logic [LANES-1:0]    s_m     [NC];
    logic [TAG_W-1:0]    s_t     [NC];

    function automatic bit enc_match(input logic [31:0] w);
        return w[6:0] == 7'h0B && w[14:12] == 3'd0 && w[31:25] == 7'd3;
    endfunction

    function automatic int dot4(input logic [31:0] a, input logic [31:0] b);
        int acc = 0;
        for (int e = 0; e < 4; e++) begin
            int x = int'($signed(a[e*8 +: 8]));
            int y = int'($signed(b[e*8 +: 8]));
            acc += x * y;
        end
        return acc;
    endfunction

    function automatic logic [31:0] mk_instr(input logic [4:0] rd);
        return {7'd3, 5'($urandom), 5'($urandom), 3'd0, rd, 7'h0B};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic check_issue(input int k);
        bit ev = s_valid[k] && enc_match(s_instr[k]);
        bit ei = s_valid[k] && !enc_match(s_instr[k]);
        check("R1 R4 R8", $sformatf("out_valid of issue %0d", k), int'(out_valid), int'(ev));
        check("R7", $sformatf("out_illegal of issue %0d", k), int'(out_illegal), int'(ei));
        if (!s_valid[k])
            check("R10", "out_wmask on idle cycle", int'(out_wmask), 0);
        else
            check("R5", "out_wmask", int'(out_wmask), ev ? int'(s_m[k]) : 0);
        if (ev) begin
            check("R6", "out_rd", int'(out_rd), int'(s_instr[k][11:7]));
            check("R6", "out_tag", int'(out_tag), int'(s_t[k]));
            for (int i = 0; i < LANES; i++) begin
                int e = s_m[k][i] ? dot4(s_a[k][i*32 +: 32], s_b[k][i*32 +: 32]) : 0;
                check("R2 R3 R5", $sformatf("lane %0d result of issue %0d", i, k),
                      int'($signed(out_result[i*32 +: 32])), e);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NC; k++) begin
            s_valid[k] = ($urandom_range(99) < 88);
            s_instr[k] = ($urandom_range(99) < 80) ? mk_instr(5'($urandom)) : $urandom;
            s_a[k]     = {$urandom, $urandom, $urandom, $urandom};
            s_b[k]     = {$urandom, $urandom, $urandom, $urandom};
            s_m[k]     = 4'($urandom);
            s_t[k]     = 6'($urandom);
        end
        // Directed corner cases at the head of the stream
        for (int k = 0; k < 9; k++) begin
            s_valid[k] = 1'b1;
            s_instr[k] = mk_instr(5'(k + 3));
            s_m[k]     = 4'hF;
        end
        s_a[0] = {16{8'h80}};  s_b[0] = {16{8'h80}};   // R3 upper extreme 65536
        s_a[1] = {16{8'h80}};  s_b[1] = {16{8'h7F}};   // R3 lower extreme -65024
        s_a[2] = {32'h00FF0000, 32'h0000FF00, 32'h02000000, 32'h00000001}; // R2 byte positions
        s_b[2] = {32'h00FF0000, 32'h00000200, 32'h03000000, 32'h00000005};
        s_m[3] = 4'b0101;                               // R5 sparse mask
        s_m[4] = 4'b0000;                               // R5 empty mask
        s_instr[5][6:0]   = 7'h33;                      // R7 opcode mismatch
        s_instr[6][31:25] = 7'd2;                       // R7 funct7 mismatch
        s_instr[7][14:12] = 3'd1;                       // R7 funct3 mismatch
        s_valid[8] = 1'b0;                              // R10 matching word, no strobe

        repeat (3) @(negedge clk);
        check("R9", "out_valid in reset", int'(out_valid), 0);
        check("R9", "out_illegal in reset", int'(out_illegal), 0);
        check("R9", "out_wmask in reset", int'(out_wmask), 0);
        rst = 1'b0;

        for (int c = 0; c < NC + 2; c++) begin
            @(negedge clk);
            if (c >= 2) check_issue(c - 2);
            if (c < NC) begin
                in_valid = s_valid[c];
                in_instr = s_instr[c];
                in_rs1   = s_a[c];
                in_rs2   = s_b[c];
                in_tmask = s_m[c];
                in_tag   = s_t[c];
            end else begin
                in_valid = 1'b0;
                in_instr = mk_instr(5'd1);
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule